// File: doc/BRIEF.md
# Seven-Operand Carry-Save Reduction Slice

This block adds seven unsigned N-bit operands in a single combinational pass. Every bit column holds one reduction cell built from five full adders. The cell takes the seven operand bits of its column and four lateral carries from the column just below it. It produces a sum bit, a carry bit for the column above, and four lateral carries for that column.

Two of the lateral carries are first-stage carries, computed from the cell's own operand bits only. The other two are second-stage carries. They depend on the cell's own bits and on the first-stage carries it received, but never on the second-stage carries it received. Lateral carries therefore settle after two cell stages, whatever the width, and a column's result draws on the two columns below it.

The slice is N+3 columns wide, so that seven maximum operands cannot overflow. Operand bits above N-1 are zero. It outputs the redundant pair of rows (sum row and carry row) and also their resolved total from a final carry-propagate adder. A parameter chooses that adder: an explicit ripple chain of full adders, or the plain addition operator.

Top module: `csa7_reduce_top`

## Requirements
- R1: `row_sum + row_carry`, taken modulo 2^(N+3), equals the arithmetic sum of the seven operands.
- R2: `total` equals the exact sum of the seven operands, with no bit lost, for every operand value.
- R3: Bit 0 of `row_carry` is always 0, because no carry enters the least significant column.
- R4: When all seven operands are zero, `row_sum`, `row_carry` and `total` are all zero.
- R5: When all seven operands are all ones, `total` equals 7 x (2^N - 1). This is 1785 for N=8 and 458745 for N=16.
- R6: When exactly one operand is nonzero, `total` equals that operand, whichever of the seven inputs carries it.
- R7: `total` equals `row_sum + row_carry` modulo 2^(N+3), for both choices of final adder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op0 | input | N | Operand 0 |
| op1 | input | N | Operand 1 |
| op2 | input | N | Operand 2 |
| op3 | input | N | Operand 3 |
| op4 | input | N | Operand 4 |
| op5 | input | N | Operand 5 |
| op6 | input | N | Operand 6 |
| row_sum | output | N+3 | Redundant sum row |
| row_carry | output | N+3 | Redundant carry row, bit 0 always zero |
| total | output | N+3 | Resolved sum of the seven operands |

## Verification
The checks inside the RTL take for granted that the operands are unsigned and hold known values. They assume no column beyond the top one is needed: the top column must produce no carry and no lateral carry, and the final adder must produce no carry-out. The three guard columns make this true for any operand values. The stimulus therefore drives every input with a defined value at all times, starting with zeros during reset. It reaches the worst case through all-ones operands, and spreads the rest between alternating patterns, single hot operands and random words, for both N=8 and N=16.

// File: rtl/c72_pkg.sv
package c72_pkg;

    // Operands reduced per column.
    localparam int OPS = 7;
    // Guard columns above the operand width: 7*(2^N-1) < 2^(N+3).
    localparam int GUARD = 3;

    // Lateral carries passed from a column to the next one up.
    // st1: depend on the source column's operand bits only.
    // st2: depend on the source column's operand bits and its st1 inputs.
    typedef struct packed {
        logic [1:0] st2;
        logic [1:0] st1;
    } lat_t;

endpackage

// File: rtl/c72_fa.sv
module c72_fa (
    input  logic a,
    input  logic b,
    input  logic ci,
    output logic s,
    output logic co
);
    always_comb begin
        s  = a ^ b ^ ci;
        co = (a & b) | (a & ci) | (b & ci);
    end
endmodule

// File: rtl/c72_cell.sv
module c72_cell
    import c72_pkg::*;
(
    input  logic [OPS-1:0] x,
    input  lat_t           cin,
    output lat_t           cout,
    output logic           s,
    output logic           c
);
    logic s1, k1, s2, k2, s3, k3, s4, k4;

    // Stage one: two independent triples of operand bits.
    c72_fa u_fa1 (.a(x[0]), .b(x[1]), .ci(x[2]), .s(s1), .co(k1));
    c72_fa u_fa2 (.a(x[3]), .b(x[4]), .ci(x[5]), .s(s2), .co(k2));
    // Stage two: partial sums with the seventh bit.
    c72_fa u_fa3 (.a(s1), .b(s2), .ci(x[6]), .s(s3), .co(k3));
    // Absorb the first-stage carries from the column below.
    c72_fa u_fa4 (.a(s3), .b(cin.st1[0]), .ci(cin.st1[1]), .s(s4), .co(k4));
    // Absorb the second-stage carries; these never feed a lateral output.
    c72_fa u_fa5 (.a(s4), .b(cin.st2[0]), .ci(cin.st2[1]), .s(s), .co(c));

    always_comb begin
        cout.st1 = {k2, k1};
        cout.st2 = {k4, k3};
    end

    // R1: eleven unit-weight inputs are conserved as s + 2c + 2*(lateral outs)
    always_comb begin
        a_r1_cell_bits: assert ($countones({x, cin}) ==
                                int'(s) + 2 * int'(c) + 2 * $countones(cout))
            else $error("cell bit count not conserved");
    end
endmodule

// File: rtl/c72_array.sv
module c72_array
    import c72_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [OPS-1:0][N-1:0] opv,
    output logic [N+GUARD-1:0]    row_s,
    output logic [N+GUARD-1:0]    row_c
);
    localparam int W = N + GUARD;

    lat_t lat_o [W];
    logic cc    [W];

    assign row_c[0] = 1'b0;

    for (genvar col = 0; col < W; col++) begin : g_col
        logic [OPS-1:0] xb;
        lat_t           lin;

        if (col < N) begin : g_data
            for (genvar k = 0; k < OPS; k++) begin : g_bit
                assign xb[k] = opv[k][col];
            end
        end else begin : g_guard
            assign xb = '0;
        end

        if (col == 0) begin : g_lsb
            assign lin = '0;
        end else begin : g_link
            assign lin = lat_o[col-1];
        end

        c72_cell u_cell (
            .x   (xb),
            .cin (lin),
            .cout(lat_o[col]),
            .s   (row_s[col]),
            .c   (cc[col])
        );

        if (col < W - 1) begin : g_crow
            assign row_c[col+1] = cc[col];
        end
    end

    // R1: the top guard column must never spill carries out of the slice
    always_comb begin
        a_r1_no_spill: assert (cc[W-1] == 1'b0 && lat_o[W-1] == '0)
            else $error("carry left the top column");
    end
endmodule

// File: rtl/c72_cpa.sv
module c72_cpa #(
    parameter int W      = 11,
    parameter bit RIPPLE = 1'b1
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    logic cout;

    if (RIPPLE) begin : g_ripple
        logic [W:0] cy;
        assign cy[0] = 1'b0;
        for (genvar i = 0; i < W; i++) begin : g_stage
            c72_fa u_fa (.a(a[i]), .b(b[i]), .ci(cy[i]), .s(y[i]), .co(cy[i+1]));
        end
        assign cout = cy[W];
    end else begin : g_behav
        assign {cout, y} = {1'b0, a} + {1'b0, b};
    end

    // R2: the resolved total fits in W bits
    always_comb begin
        a_r2_cpa_no_carry: assert (cout == 1'b0)
            else $error("final adder overflowed");
    end
endmodule

// File: rtl/csa7_reduce_top.sv
module csa7_reduce_top
    import c72_pkg::*;
#(
    parameter int N          = 8,
    parameter bit CPA_RIPPLE = 1'b1
) (
    input  logic [N-1:0]       op0,
    input  logic [N-1:0]       op1,
    input  logic [N-1:0]       op2,
    input  logic [N-1:0]       op3,
    input  logic [N-1:0]       op4,
    input  logic [N-1:0]       op5,
    input  logic [N-1:0]       op6,
    output logic [N+GUARD-1:0] row_sum,
    output logic [N+GUARD-1:0] row_carry,
    output logic [N+GUARD-1:0] total
);
    localparam int W = N + GUARD;

    logic [OPS-1:0][N-1:0] opv;
    assign opv = {op6, op5, op4, op3, op2, op1, op0};

    c72_array #(.N(N)) u_array (
        .opv  (opv),
        .row_s(row_sum),
        .row_c(row_carry)
    );

    c72_cpa #(.W(W), .RIPPLE(CPA_RIPPLE)) u_cpa (
        .a(row_sum),
        .b(row_carry),
        .y(total)
    );

    logic [W-1:0] ref_sum;
    always_comb begin
        ref_sum = '0;
        for (int k = 0; k < OPS; k++) ref_sum = ref_sum + W'(opv[k]);
    end

    // R2: total is the exact sum of the seven operands
    always_comb begin
        a_r2_exact_total: assert (total == ref_sum)
            else $error("total differs from operand sum");
    end

    // R7: total resolves the two redundant rows
    always_comb begin
        a_r7_rows_resolve: assert (total == W'(row_sum + row_carry))
            else $error("total differs from row sum");
    end
endmodule

// File: tb/sim_csa7_reduce_top.sv
module sim_csa7_reduce_top;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;

    localparam logic [15:0] VEC [NV][7] = '{
        '{16'hAAAA, 16'h5555, 16'hAAAA, 16'h5555, 16'hAAAA, 16'h5555, 16'hAAAA},
        '{16'h5555, 16'h5555, 16'h5555, 16'h5555, 16'h5555, 16'h5555, 16'h5555},
        '{16'h0001, 16'h0001, 16'h0001, 16'h0001, 16'h0001, 16'h0001, 16'h0001},
        '{16'h8080, 16'h8080, 16'h8080, 16'h8080, 16'h8080, 16'h8080, 16'h8080},
        '{16'hFFFF, 16'h0000, 16'hFFFF, 16'h0000, 16'hFFFF, 16'h0000, 16'hFFFF},
        '{16'h1234, 16'h5678, 16'h9ABC, 16'hDEF0, 16'h0F0F, 16'hF0F0, 16'h3C3C},
        '{16'hFFFE, 16'h7FFF, 16'h0001, 16'h8000, 16'hC3C3, 16'h00FF, 16'hFF00},
        '{16'h0003, 16'h000C, 16'h0030, 16'h00C0, 16'h0300, 16'h0C00, 16'h3000}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [15:0] a [7];
    logic [10:0] r0s, r0c, r0t;
    logic [18:0] r1s, r1c, r1t;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    csa7_reduce_top #(.N(8), .CPA_RIPPLE(1'b1)) u0 (
        .op0(a[0][7:0]), .op1(a[1][7:0]), .op2(a[2][7:0]), .op3(a[3][7:0]),
        .op4(a[4][7:0]), .op5(a[5][7:0]), .op6(a[6][7:0]),
        .row_sum(r0s), .row_carry(r0c), .total(r0t)
    );

    csa7_reduce_top #(.N(16), .CPA_RIPPLE(1'b0)) u1 (
        .op0(a[0]), .op1(a[1]), .op2(a[2]), .op3(a[3]),
        .op4(a[4]), .op5(a[5]), .op6(a[6]),
        .row_sum(r1s), .row_carry(r1c), .total(r1t)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic apply(logic [15:0] v [7]);
        @(posedge clk);
        for (int k = 0; k < 7; k++) a[k] = v[k];
        @(negedge clk);
    endtask

    // R1, R2, R3, R7 on both widths
    task automatic check_rows();
        int e8, e16;
        e8 = 0; e16 = 0;
        for (int k = 0; k < 7; k++) begin
            e8  += int'(a[k][7:0]);
            e16 += int'(a[k]);
        end
        chk("R1 n8",  (int'(r0s) + int'(r0c)) % 2048,   e8);
        chk("R1 n16", (int'(r1s) + int'(r1c)) % 524288, e16);
        chk("R2 n8",  int'(r0t), e8);
        chk("R2 n16", int'(r1t), e16);
        chk("R3 n8",  int'(r0c[0]), 0);
        chk("R3 n16", int'(r1c[0]), 0);
        chk("R7 n8",  int'(r0t), (int'(r0s) + int'(r0c)) % 2048);
        chk("R7 n16", int'(r1t), (int'(r1s) + int'(r1c)) % 524288);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] v [7];
        for (int k = 0; k < 7; k++) a[k] = 16'h0;

        // R4: reset state with zero operands
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R4 sum n8",    int'(r0s), 0);
        chk("R4 carry n8",  int'(r0c), 0);
        chk("R4 total n8",  int'(r0t), 0);
        chk("R4 sum n16",   int'(r1s), 0);
        chk("R4 carry n16", int'(r1c), 0);
        chk("R4 total n16", int'(r1t), 0);
        rst = 1'b0;

        // Vector table
        for (int i = 0; i < NV; i++) begin
            for (int k = 0; k < 7; k++) v[k] = VEC[i][k];
            apply(v);
            check_rows();
        end

        // R5: all ones, worst case
        for (int k = 0; k < 7; k++) v[k] = 16'hFFFF;
        apply(v);
        chk("R5 n8",  int'(r0t), 1785);
        chk("R5 n16", int'(r1t), 458745);
        check_rows();

        // R6: single hot operand on each input
        for (int p = 0; p < 7; p++) begin
            for (int k = 0; k < 7; k++) v[k] = 16'h0;
            v[p] = 16'hA5C3 ^ (16'h1111 << p);
            apply(v);
            chk("R6 n8",  int'(r0t), int'(v[p][7:0]));
            chk("R6 n16", int'(r1t), int'(v[p]));
        end

        // Random operands
        for (int i = 0; i < 300; i++) begin
            for (int k = 0; k < 7; k++) v[k] = 16'($urandom);
            apply(v);
            check_rows();
        end

        // R4: back to zero after activity
        for (int k = 0; k < 7; k++) v[k] = 16'h0;
        apply(v);
        chk("R4 total n8 after",  int'(r0t), 0);
        chk("R4 total n16 after", int'(r1t), 0);
        chk("R4 sum n16 after",   int'(r1s), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule